// File: doc/BRIEF.md
# Idle-timeout functional unit power gate

This block decides when the power domains of a multiply unit and a divide unit are switched on and off. Each unit runs its own small state machine. An instruction decoder reports which unit the instruction now in the pipeline needs, and a separate power sequencer carries out each switch, returning a one-cycle completion pulse. The arithmetic units and the sequencer are outside this block.

In automatic mode a unit is powered only when an instruction asks for it. The pipeline is held while the unit comes up, which is the only stall this mode adds. An 8-bit idle counter is cleared by every use. When it wraps on an unused cycle, the unit is released. In always-on mode the unit is requested permanently. Its counter keeps running during that time, so when automatic mode returns, the unit drops at the counter's next wrap and not at once.

Top module: `fu_idle_gate`

## Requirements
- R1: After reset, `pwr_req_o` is 2'b00 and `hold_o` is 0.
- R2: When a unit is off and either its `need_i` bit or its `always_on_i` bit is 1 at a clock edge, its `pwr_req_o` bit is 1 from that edge on. The bit stays 1 until the sequencer's `seq_done_i` pulse marks the unit as fully powered.
- R3: `hold_o` is 1 in every cycle in which some unit's `need_i` bit is 1 and that unit is not yet fully powered. It falls in the first cycle after the power-up completion pulse.
- R4: When every needed unit is fully powered, `hold_o` is 0.
- R5: A cycle in which a powered unit's `need_i` bit is 1 restarts that unit's idle count from zero.
- R6: In automatic mode (`always_on_i` bit 0), a powered unit's `pwr_req_o` bit falls at the clock edge that ends its 256th consecutive unused cycle.
- R7: While a unit's `always_on_i` bit is 1, its `pwr_req_o` bit is 1 once it has powered up, and it never falls, whatever the use.
- R8: While the mode is always on, the idle count keeps running and wraps every 256 cycles. After the `always_on_i` bit returns to 0, the request falls at the next wrap of that count, not at once.
- R9: A need that arrives while a unit is powering down holds the pipeline. It waits for the power-down completion pulse, and then a fresh power-up request is raised.
- R10: The two units are independent. A stall or a power-up of one does not change the other's idle count.
- R11: Bit 0 of each 2-bit vector belongs to the multiply unit and bit 1 belongs to the divide unit. On `always_on_i`, 0 means automatic and 1 means always on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| always_on_i | input | 2 | Mode per unit: 0 automatic, 1 always on |
| need_i | input | 2 | Decoded flag: the current instruction uses this unit |
| seq_done_i | input | 2 | One-cycle pulse: the requested power change is complete |
| pwr_req_o | output | 2 | Level request: 1 power the unit on, 0 power it off |
| hold_o | output | 1 | Pipeline hold during wake-up |

## Verification
The hardest case to reach is a need that arrives while a unit is powering down (R9). It needs a unit that has timed out and a sequencer that has not yet acknowledged the drop. The bench sequencer answers each request change only after a fixed latency. The stimulus polls for the falling request and raises the need in that same cycle. The exact wrap timing after always on is released (R8) is reached by clearing the count with a single use in the same cycle that the mode bit is released.

// File: rtl/fu_idle_gate.sv
module fu_idle_gate #(
  parameter int NUNITS = 2,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUNITS-1:0] always_on_i,
  input  logic [NUNITS-1:0] need_i,
  input  logic [NUNITS-1:0] seq_done_i,
  output logic [NUNITS-1:0] pwr_req_o,
  output logic              hold_o
);
  typedef enum logic [1:0] {S_OFF, S_WAKE, S_ON, S_SLEEP} gate_st_t;

  logic [NUNITS-1:0] powered;

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    gate_st_t          st_q;
    logic [IDLE_W-1:0] idle_q;
    logic              expire;

    assign expire = (&idle_q) & ~need_i[u] & ~always_on_i[u];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= S_OFF;
        idle_q <= '0;
      end else begin
        case (st_q)
          S_OFF:   if (need_i[u] || always_on_i[u]) st_q <= S_WAKE;
          S_WAKE:  if (seq_done_i[u]) begin
                     st_q   <= S_ON;
                     idle_q <= '0;
                   end
          S_ON:    if (need_i[u]) idle_q <= '0;
                   else if (expire) st_q <= S_SLEEP;
                   else idle_q <= idle_q + 1'b1;
          default: if (seq_done_i[u]) st_q <= S_OFF;
        endcase
      end
    end

    assign pwr_req_o[u] = (st_q == S_WAKE) || (st_q == S_ON);
    assign powered[u]   = (st_q == S_ON);
  end

  assign hold_o = |(need_i & ~powered);
endmodule

module fu_idle_gate_chk #(
  parameter int NUNITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUNITS-1:0] always_on_i,
  input logic [NUNITS-1:0] need_i,
  input logic [NUNITS-1:0] seq_done_i,
  input logic [NUNITS-1:0] pwr_req_o,
  input logic [NUNITS-1:0] powered,
  input logic              hold_o
);
  p_hold_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> (need_i != '0));

  p_no_hold_when_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (powered == {NUNITS{1'b1}}) |-> !hold_o);

  for (genvar u = 0; u < NUNITS; u++) begin : g_chk
    p_wake_persists_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_req_o[u] && !powered[u] && !seq_done_i[u]) |=> pwr_req_o[u]);

    p_use_keeps_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (need_i[u] && powered[u]) |=> (pwr_req_o[u] && powered[u]));

    p_always_on_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (always_on_i[u] && powered[u]) |=> pwr_req_o[u]);
  end
endmodule

bind fu_idle_gate fu_idle_gate_chk #(.NUNITS(NUNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .always_on_i(always_on_i), .need_i(need_i),
  .seq_done_i(seq_done_i), .pwr_req_o(pwr_req_o), .powered(powered), .hold_o(hold_o));

// File: tb/fu_idle_gate_tb_top.sv
`timescale 1ns/1ps
module fu_idle_gate_tb_top;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] always_on_i = '0;
  logic [1:0] need_i = '0;
  logic [1:0] seq_done_i = '0;
  logic [1:0] pwr_req_o;
  logic       hold_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  fu_idle_gate dut_i (
    .clk(clk), .rst_n(rst_n), .always_on_i(always_on_i), .need_i(need_i),
    .seq_done_i(seq_done_i), .pwr_req_o(pwr_req_o), .hold_o(hold_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Power sequencer: answers a request change after LAT cycles with a pulse.
  int seen [2] = '{0, 0};
  int wait_n [2] = '{0, 0};
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      seq_done_i[u] <= 1'b0;
      if (int'(pwr_req_o[u]) != seen[u]) begin
        if (wait_n[u] == LAT) begin
          seq_done_i[u] <= 1'b1;
          seen[u]   = int'(pwr_req_o[u]);
          wait_n[u] = 0;
        end else wait_n[u]++;
      end
    end
  end

  // Reference model: phase 0 off, 1 waking, 2 on, 3 sleeping; idle cycles since last use.
  int ph [2] = '{0, 0};
  int idle [2] = '{0, 0};
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      int exp_hold;
      exp_hold = 0;
      for (int u = 0; u < 2; u++) begin
        check({tag, " req"}, int'(pwr_req_o[u]), (ph[u] == 1 || ph[u] == 2) ? 1 : 0);
        if (need_i[u] && ph[u] != 2) exp_hold = 1;
      end
      check({tag, " hold"}, int'(hold_o), exp_hold);
      for (int u = 0; u < 2; u++) begin
        if (ph[u] == 0) begin
          if (need_i[u] || always_on_i[u]) ph[u] = 1;
        end else if (ph[u] == 1) begin
          if (seq_done_i[u]) begin ph[u] = 2; idle[u] = 0; end
        end else if (ph[u] == 2) begin
          if (need_i[u]) idle[u] = 0;
          else if ((idle[u] + 1) % 256 == 0 && !always_on_i[u]) ph[u] = 3;
          else idle[u]++;
        end else if (seq_done_i[u]) ph[u] = 0;
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_until_hold_low();
    for (int i = 0; i < 50 && hold_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset req", int'(pwr_req_o), 0);
    check("R1 reset hold", int'(hold_o), 0);
    rst_n = 1'b1;

    // R2 R3 R11: multiply need wakes bit 0 only
    tag = "R2";
    @(negedge clk); need_i = 2'b01;
    @(negedge clk);
    check("R3 hold during wake", int'(hold_o), 1);
    check("R2 mul req raised", int'(pwr_req_o[0]), 1);
    check("R11 div untouched", int'(pwr_req_o[1]), 0);
    wait_until_hold_low();
    check("R4 no hold once on", int'(hold_o), 0);
    check("R2 req kept", int'(pwr_req_o[0]), 1);

    // R5 R6: use restarts the count, 256 idle cycles drop power
    tag = "R6";
    @(negedge clk); need_i = 2'b00;
    repeat (200) @(negedge clk);
    need_i = 2'b01;
    @(negedge clk);
    check("R4 no hold on use", int'(hold_o), 0);
    need_i = 2'b00;
    repeat (255) @(negedge clk);
    check("R5 still on after 255 idle", int'(pwr_req_o[0]), 1);
    @(negedge clk);
    check("R6 off after 256 idle", int'(pwr_req_o[0]), 0);
    repeat (10) @(negedge clk);

    // R9: need while powering down
    tag = "R9";
    need_i = 2'b01;
    @(negedge clk); wait_until_hold_low();
    @(negedge clk); need_i = 2'b00;
    for (int i = 0; i < 300 && pwr_req_o[0]; i++) @(negedge clk);
    need_i = 2'b01;
    @(negedge clk);
    check("R9 hold while sleeping", int'(hold_o), 1);
    check("R9 no req before done", int'(pwr_req_o[0]), 0);
    for (int i = 0; i < 50 && !pwr_req_o[0]; i++) @(negedge clk);
    check("R9 re-request", int'(pwr_req_o[0]), 1);
    check("R9 hold kept", int'(hold_o), 1);
    wait_until_hold_low();
    @(negedge clk); need_i = 2'b00;

    // R7: divide always on
    tag = "R7";
    always_on_i = 2'b10;
    repeat (10) @(negedge clk);
    check("R7 div on without need", int'(pwr_req_o[1]), 1);
    repeat (600) @(negedge clk);
    check("R7 div still on", int'(pwr_req_o[1]), 1);
    need_i = 2'b10;
    @(negedge clk);
    check("R4 no hold div on", int'(hold_o), 0);

    // R8: release waits for the next wrap
    tag = "R8";
    need_i = 2'b00; always_on_i = 2'b00;
    @(negedge clk);
    check("R8 not immediate", int'(pwr_req_o[1]), 1);
    repeat (254) @(negedge clk);
    check("R8 on before wrap", int'(pwr_req_o[1]), 1);
    @(negedge clk);
    check("R8 off at wrap", int'(pwr_req_o[1]), 0);
    repeat (20) @(negedge clk);

    // R10: divide wake-up does not disturb multiply count
    tag = "R10";
    need_i = 2'b01;
    @(negedge clk); wait_until_hold_low();
    @(negedge clk); need_i = 2'b10;
    repeat (255) @(negedge clk);
    check("R10 mul on", int'(pwr_req_o[0]), 1);
    check("R10 div on", int'(pwr_req_o[1]), 1);
    @(negedge clk);
    check("R10 mul dropped on time", int'(pwr_req_o[0]), 0);
    check("R10 div kept", int'(pwr_req_o[1]), 1);
    need_i = 2'b00;
    repeat (5) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule